// File: doc/BRIEF.md
# LDPC Check-Node Extrinsic Message Unit

This block performs the check-node half of a log-domain belief-propagation LDPC decoder for a single parity check of degree `DEG`. It receives all `DEG` incoming edge messages in one beat. Each message is a sign bit plus a 2.4 fixed-point magnitude. One clock later the block returns `DEG` extrinsic messages, one for each edge, and each of these excludes the edge's own input.

The block uses the sign/magnitude form of the tanh rule. Every input magnitude is passed through the self-inverse function phi(x) = ln((1+e^-x)/(1-e^-x)), implemented as a table that is computed at elaboration. The mapped values are summed with saturation. For each edge, that edge's own mapped value is subtracted from the sum, and the difference is passed through the same table again. Every addition and subtraction uses sign-magnitude arithmetic that works by comparing magnitudes. The output sign of an edge is the parity of all the other input signs. Variable-node processing lies outside this block.

Top module: `ldpc_cnu`

## Requirements
- R1: Edge j of `msg_i` and `msg_o` occupies bits [7j+6:7j]. Bit 7j+6 is the sign (1 means negative), and bits 7j+5:7j hold an unsigned magnitude in 2.4 fixed point, so a code c stands for c/16.
- R2: The table entry for magnitude code k is min(63, floor(16·phi(k/16))), where phi(x) = ln((1+e^-x)/(1-e^-x)). The entry for k = 0 is 63.
- R3: The sign-magnitude adder works as follows. With equal signs it adds the magnitudes, keeps the common sign, and saturates at 63. With different signs it subtracts the smaller magnitude from the larger and takes the sign of the larger; equal magnitudes give a positive zero. Subtraction inverts the second operand's sign first.
- R4: The sum S of the table values of all edges saturates at 63 and never wraps.
- R5: The output magnitude of edge j is table(S - table(|m_j|)).
- R6: The output sign of edge j is the XOR of the signs of every input edge except j.
- R7: `valid_o` is high in exactly the cycle after a cycle in which `valid_i` was sampled high. The results appear on `msg_o` in that same cycle.
- R8: When `valid_i` is low, `msg_o` keeps its previous value, whatever `msg_i` carries.
- R9: While `rst_n` is sampled low, `valid_o` and `msg_o` are cleared to zero on the clock edge, regardless of `valid_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Input messages valid |
| msg_i | input | DEG*(MAG_W+1) | Incoming edge messages, packed by edge |
| valid_o | output | 1 | Extrinsic messages valid |
| msg_o | output | DEG*(MAG_W+1) | Extrinsic edge messages, packed by edge |

## Verification
The first pattern is a full sweep of one edge's magnitude, with the other edges held at the largest magnitude. It exposes every table entry through a double table lookup and separates an off-by-one in the table from a wrong subtraction. Exhaustive sign combinations on three edges show whether the parity excludes the edge's own sign. All-small magnitudes drive the sum into saturation, which a wrapping adder would get wrong. Random traffic with gaps in the valid strobe, and cycles where only the data changes, separate the latency from the hold behaviour.

// File: rtl/cnu_pkg.sv
// Package: shared defaults and the operation selector for the sign-magnitude adder.
// Assumes: nothing beyond being compiled before the modules that import it.
package cnu_pkg;
    localparam int CNU_DEG_DEF  = 3;
    localparam int CNU_MAG_DEF  = 6;
    localparam int CNU_FRAC_DEF = 4;

    typedef enum logic {
        SM_ADD = 1'b0,
        SM_SUB = 1'b1
    } sm_op_e;
endpackage

// File: rtl/cnu_phi_lut.sv
// Module: combinational phi table, phi(x) = ln((1+e^-x)/(1-e^-x)).
// Each entry is floor(16*phi(k/16)), clamped to the largest code; code 0 maps to the largest code.
// Assumes: magnitudes are unsigned with FRAC_W fraction bits; the table is fixed at elaboration.
module cnu_phi_lut #(
    parameter int MAG_W  = 6,
    parameter int FRAC_W = 4
) (
    input  logic [MAG_W-1:0] mag_i,
    output logic [MAG_W-1:0] phi_o
);
    localparam int N_ENT = 2 ** MAG_W;
    localparam int MAXV  = N_ENT - 1;
    localparam int SCALE = 2 ** FRAC_W;

    logic [MAG_W-1:0] tbl [N_ENT];

    // One entry per magnitude code, computed from the real-valued function.
    for (genvar k = 0; k < N_ENT; k++) begin : g_ent
        localparam real XV = (k == 0) ? 1.0 : real'(k) / real'(SCALE);
        localparam real FV = $ln((1.0 + $exp(-XV)) / (1.0 - $exp(-XV))) * real'(SCALE);
        localparam int  EV = (k == 0 || FV >= real'(MAXV)) ? MAXV : $rtoi(FV);
        assign tbl[k] = MAG_W'(EV);
    end

    // Table read.
    assign phi_o = tbl[mag_i];
endmodule

// File: rtl/cnu_sm_addsub.sv
// Module: sign-magnitude adder/subtractor that decides the result by comparing magnitudes.
// Equal signs: magnitudes add and saturate. Different signs: larger minus smaller, sign of the larger.
// Equal magnitudes with different signs give a positive zero. SM_SUB inverts the second sign first.
// Assumes: both operands share the magnitude width MAG_W.
module cnu_sm_addsub
    import cnu_pkg::*;
#(
    parameter int MAG_W = 6
) (
    input  sm_op_e           op_i,
    input  logic             a_sgn_i,
    input  logic [MAG_W-1:0] a_mag_i,
    input  logic             b_sgn_i,
    input  logic [MAG_W-1:0] b_mag_i,
    output logic             r_sgn_o,
    output logic [MAG_W-1:0] r_mag_o
);
    logic             b_eff;
    logic [MAG_W:0]   wide_sum;

    // Effective sign of the second operand and the widened magnitude sum.
    assign b_eff    = b_sgn_i ^ (op_i == SM_SUB);
    assign wide_sum = {1'b0, a_mag_i} + {1'b0, b_mag_i};

    // Result selection by sign agreement and magnitude comparison.
    always_comb begin
        if (a_sgn_i == b_eff) begin
            r_sgn_o = a_sgn_i;
            r_mag_o = wide_sum[MAG_W] ? {MAG_W{1'b1}} : wide_sum[MAG_W-1:0];
        end else if (a_mag_i >= b_mag_i) begin
            r_mag_o = a_mag_i - b_mag_i;
            r_sgn_o = (a_mag_i == b_mag_i) ? 1'b0 : a_sgn_i;
        end else begin
            r_mag_o = b_mag_i - a_mag_i;
            r_sgn_o = b_eff;
        end
    end
endmodule

// File: rtl/ldpc_cnu.sv
// Module: check-node unit computing DEG extrinsic messages with the phi-table tanh rule.
// Maps each input magnitude through phi, sums with saturation, subtracts each edge's own term,
// maps back through phi, and assigns each edge the parity of the other signs. One register stage.
// Assumes: edge j sits at bits [j*(MAG_W+1) +: MAG_W+1], sign in the top bit of each field.
module ldpc_cnu
    import cnu_pkg::*;
#(
    parameter int DEG    = CNU_DEG_DEF,
    parameter int MAG_W  = CNU_MAG_DEF,
    parameter int FRAC_W = CNU_FRAC_DEF
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         valid_i,
    input  logic [DEG*(MAG_W+1)-1:0]     msg_i,
    output logic                         valid_o,
    output logic [DEG*(MAG_W+1)-1:0]     msg_o
);
    localparam int MSG_W = MAG_W + 1;
    localparam int BUS_W = DEG * MSG_W;
    localparam logic [MAG_W-1:0] MAXV = {MAG_W{1'b1}};

    logic [DEG-1:0]   sgn_in;
    logic [DEG-1:0]   sgn_out;
    logic             sgn_all;
    logic [MAG_W-1:0] mag_in   [DEG];
    logic [MAG_W-1:0] phi_in   [DEG];
    logic [MAG_W-1:0] acc_mag  [DEG];
    logic             acc_sgn  [DEG];
    logic [MAG_W-1:0] diff_mag [DEG];
    logic             diff_sgn [DEG];
    logic [MAG_W-1:0] phi_out  [DEG];
    logic [BUS_W-1:0] msg_next;

    // Per-edge field split and forward table lookup.
    for (genvar j = 0; j < DEG; j++) begin : g_in
        assign sgn_in[j] = msg_i[j*MSG_W + MAG_W];
        assign mag_in[j] = msg_i[j*MSG_W +: MAG_W];
        cnu_phi_lut #(.MAG_W(MAG_W), .FRAC_W(FRAC_W)) u_lut_in (
            .mag_i (mag_in[j]),
            .phi_o (phi_in[j])
        );
    end

    // Saturating accumulation chain of the mapped magnitudes.
    assign acc_mag[0] = phi_in[0];
    assign acc_sgn[0] = 1'b0;
    for (genvar j = 1; j < DEG; j++) begin : g_acc
        cnu_sm_addsub #(.MAG_W(MAG_W)) u_acc (
            .op_i    (SM_ADD),
            .a_sgn_i (acc_sgn[j-1]),
            .a_mag_i (acc_mag[j-1]),
            .b_sgn_i (1'b0),
            .b_mag_i (phi_in[j]),
            .r_sgn_o (acc_sgn[j]),
            .r_mag_o (acc_mag[j])
        );
    end

    // Exclusion of each edge's own term and reverse table lookup.
    for (genvar j = 0; j < DEG; j++) begin : g_out
        cnu_sm_addsub #(.MAG_W(MAG_W)) u_excl (
            .op_i    (SM_SUB),
            .a_sgn_i (acc_sgn[DEG-1]),
            .a_mag_i (acc_mag[DEG-1]),
            .b_sgn_i (1'b0),
            .b_mag_i (phi_in[j]),
            .r_sgn_o (diff_sgn[j]),
            .r_mag_o (diff_mag[j])
        );
        cnu_phi_lut #(.MAG_W(MAG_W), .FRAC_W(FRAC_W)) u_lut_out (
            .mag_i (diff_mag[j]),
            .phi_o (phi_out[j])
        );
        assign sgn_out[j] = sgn_all ^ sgn_in[j];

        // R4: the saturated sum is never below any single mapped term.
        a_r4_sum_covers: assert property (@(posedge clk) disable iff (!rst_n)
            valid_i |-> (acc_mag[DEG-1] >= phi_in[j]) && !diff_sgn[j]);
        // R2: a zero magnitude maps to the largest code.
        a_r2_zero_sat: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_i && mag_in[j] == '0) |-> (phi_in[j] == MAXV));
    end

    // Parity of all input signs.
    assign sgn_all = ^sgn_in;

    // Packing of the next output word.
    always_comb begin
        msg_next = '0;
        for (int j = 0; j < DEG; j++) begin
            msg_next[j*MSG_W +: MSG_W] = {sgn_out[j], phi_out[j]};
        end
    end

    // Output register: cleared by reset, loaded only on a valid beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            msg_o   <= '0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) begin
                msg_o <= msg_next;
            end
        end
    end

    // R7: one-cycle strobe latency.
    a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (valid_o == $past(valid_i)));
    // R8: output word holds when no beat was accepted.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(valid_i)) |-> $stable(msg_o));
    // R6: parity of output signs follows from excluding each edge once.
    a_r6_sign_parity: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && valid_o) |->
        ((^sgn_out_q()) == ((DEG % 2 == 1) ? 1'b0 : ^$past(sgn_in))));

    function automatic logic [DEG-1:0] sgn_out_q();
        logic [DEG-1:0] s;
        for (int j = 0; j < DEG; j++) s[j] = msg_o[j*MSG_W + MAG_W];
        return s;
    endfunction
endmodule

// File: tb/test_ldpc_cnu.sv
// Bench: behavioural reference model updated at each rising edge, compared at every falling edge.
module test_ldpc_cnu;
    localparam int DEG   = 3;
    localparam int MAG_W = 6;
    localparam int FRAC  = 4;
    localparam int MSG_W = MAG_W + 1;
    localparam int MAXV  = 63;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   valid_i = 1'b0;
    logic [DEG*MSG_W-1:0]   msg_i = '0;
    logic                   valid_o;
    logic [DEG*MSG_W-1:0]   msg_o;

    int    checks = 0;
    int    errors = 0;
    string tag = "R9";
    bit    started = 1'b0;
    bit    exp_valid = 1'b0;
    logic [DEG*MSG_W-1:0] exp_msg = '0;

    always #5 clk = ~clk;

    ldpc_cnu #(.DEG(DEG), .MAG_W(MAG_W), .FRAC_W(FRAC)) i_ldpc_cnu (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (valid_i),
        .msg_i   (msg_i),
        .valid_o (valid_o),
        .msg_o   (msg_o)
    );

    // R2: table value from its definition.
    function automatic int phi_ref(int k);
        real x, v;
        if (k == 0) return MAXV;
        x = k / 16.0;
        v = $ln((1.0 + $exp(-x)) / (1.0 - $exp(-x))) * 16.0;
        if (v >= 63.0) return MAXV;
        return $rtoi(v);
    endfunction

    // R4, R5, R6: expected output word.
    function automatic logic [DEG*MSG_W-1:0] model(logic [DEG*MSG_W-1:0] m);
        logic [DEG*MSG_W-1:0] r;
        int s = 0;
        int ph [DEG];
        bit tot = 1'b0;
        for (int j = 0; j < DEG; j++) begin
            ph[j] = phi_ref(int'(m[j*MSG_W +: MAG_W]));
            s += ph[j];
            tot ^= m[j*MSG_W + MAG_W];
        end
        if (s > MAXV) s = MAXV;
        for (int j = 0; j < DEG; j++) begin
            r[j*MSG_W +: MSG_W] = {tot ^ m[j*MSG_W + MAG_W], 6'(phi_ref(s - ph[j]))};
        end
        return r;
    endfunction

    // R1: one edge field.
    function automatic logic [MSG_W-1:0] fld(bit s, int mag);
        return {s, 6'(mag)};
    endfunction

    // Reference update at each rising edge (R7, R8, R9).
    always @(posedge clk) begin
        started = 1'b1;
        if (!rst_n) begin
            exp_valid = 1'b0;
            exp_msg   = '0;
        end else begin
            exp_valid = valid_i;
            if (valid_i) exp_msg = model(msg_i);
        end
    end

    // Comparison at each falling edge.
    always @(negedge clk) begin
        if (started) begin
            checks++;
            if (valid_o !== exp_valid) begin
                errors++;
                $display("FAIL R7 [%s] valid_o actual %0b expected %0b", tag, valid_o, exp_valid);
            end
            for (int j = 0; j < DEG; j++) begin
                checks++;
                if (msg_o[j*MSG_W +: MAG_W] !== exp_msg[j*MSG_W +: MAG_W]) begin
                    errors++;
                    $display("FAIL %s edge %0d magnitude actual %0d expected %0d", tag, j,
                             msg_o[j*MSG_W +: MAG_W], exp_msg[j*MSG_W +: MAG_W]);
                end
                checks++;
                if (msg_o[j*MSG_W + MAG_W] !== exp_msg[j*MSG_W + MAG_W]) begin
                    errors++;
                    $display("FAIL R6 [%s] edge %0d sign actual %0b expected %0b", tag, j,
                             msg_o[j*MSG_W + MAG_W], exp_msg[j*MSG_W + MAG_W]);
                end
            end
        end
    end

    task automatic send(input bit v, input logic [DEG*MSG_W-1:0] m);
        @(negedge clk);
        valid_i = v;
        msg_i   = m;
    endtask

    // Watchdog.
    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Stimulus.
    initial begin
        // R9: reset clears outputs even with a valid beat presented.
        tag = "R9";
        valid_i = 1'b1;
        msg_i   = {fld(1, 9), fld(0, 17), fld(1, 33)};
        repeat (3) @(negedge clk);
        send(1'b0, '0);
        rst_n = 1'b1;

        // R1: distinct edge fields reveal the field order.
        tag = "R1";
        send(1'b1, {fld(0, 63), fld(1, 20), fld(0, 5)});
        send(1'b1, {fld(1, 2), fld(0, 40), fld(0, 63)});

        // R2: sweep one edge through every magnitude code.
        tag = "R2";
        for (int k = 0; k < 64; k++) send(1'b1, {fld(0, 63), fld(0, 63), fld(0, k)});

        // R6: every sign combination.
        tag = "R6";
        for (int s = 0; s < 8; s++) send(1'b1, {fld(s[2], 10), fld(s[1], 30), fld(s[0], 50)});

        // R4: saturation of the sum.
        tag = "R4";
        send(1'b1, {fld(0, 0), fld(0, 0), fld(0, 0)});
        send(1'b1, {fld(0, 1), fld(1, 1), fld(0, 1)});
        send(1'b1, {fld(0, 2), fld(0, 40), fld(1, 3)});

        // R5: equal and near-equal magnitudes across edges.
        tag = "R5";
        for (int a = 4; a < 64; a += 6) send(1'b1, {fld(0, a), fld(1, a), fld(0, 64 - a)});

        // R3: random traffic through both sign-magnitude stages.
        tag = "R3";
        for (int n = 0; n < 60; n++)
            send(1'b1, {fld($urandom_range(1), $urandom_range(63)),
                        fld($urandom_range(1), $urandom_range(63)),
                        fld($urandom_range(1), $urandom_range(63))});

        // R8: data changes without a valid beat.
        tag = "R8";
        send(1'b1, {fld(1, 12), fld(0, 7), fld(1, 25)});
        for (int n = 0; n < 6; n++)
            send(1'b0, {fld($urandom_range(1), $urandom_range(63)),
                        fld($urandom_range(1), $urandom_range(63)),
                        fld($urandom_range(1), $urandom_range(63))});

        // R7: irregular strobe pattern.
        tag = "R7";
        for (int n = 0; n < 24; n++)
            send(n % 3 != 1, {fld(n[0], n + 3), fld(n[1], 2 * n), fld(n[2], 60 - n)});

        send(1'b0, '0);
        repeat (3) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule